// File: doc/BRIEF.md
# Audio word-clock supervisor

This block sits beside the frame sequencer of a serial audio port and watches the two clocks of the link: the frame (word) clock and the bit clock. Both clocks arrive asynchronously. Each is brought into the system-clock domain through a two-stage synchronizer, and edges are found by comparing the synchronized level with its value one cycle earlier. From those edges the block raises two sticky status flags. The first is a timeout flag, raised when the frame clock has stopped toggling. The second is a framing-error flag, raised when the frame clock moves at a moment the link format does not allow.

The framing rules depend on the phase mode. In either mode, a frame-clock edge that lands in the data-delay part of a phase is an error. Edges seen in the word or idle parts are not treated as errors by that rule. In dual-phase mode, two frame-clock edges separated by fewer than four bit-clock rising edges are an error. In single-phase multichannel mode, a rising frame-clock edge is an error if it comes before the sequencer has completed the programmed number of channel words. A framing error means word alignment is lost and the link needs a full restart. Clearing the error flag therefore also re-arms the interval and channel rules, so the first frame-clock edge after a clear is only taken as a new reference.

Both flags are plain status pins. Each has its own write-1-to-clear strobe. A flag holds until its strobe is pulsed, and a new event in the same cycle as the strobe wins over the clear. The block has no data stream, so no valid/ready handshake applies.

Top module: `wclk_supervisor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, both `timeout_flag` and `wclk_err_flag` read 0.
- R2: If no rising frame-clock edge is detected for TIMEOUT_CYCLES (default 65535) consecutive system-clock cycles after reset, `timeout_flag` rises.
- R3: Each detected rising frame-clock edge restarts the timeout count from zero. The count saturates and does not wrap, so once `timeout_flag` is cleared it does not rise again until a rising edge is followed by another full timeout window.
- R4: In either phase mode, a frame-clock edge of either polarity sets `wclk_err_flag` when it is detected while `frame_period` holds the data-delay code 0. The flag rises within 3 system-clock cycles of the raw input change.
- R5: Frame-clock edges detected while `frame_period` holds the word code 1 or the idle code 2 do not set `wclk_err_flag` through the data-delay rule.
- R6: With `dual_phase` = 1, a frame-clock edge of either polarity sets `wclk_err_flag` when fewer than 4 bit-clock rising edges have been detected since the previous frame-clock edge. A gap of 4 or more is accepted.
- R7: With `dual_phase` = 0, a rising frame-clock edge sets `wclk_err_flag` when fewer than `num_chan` words have completed since the previous rising edge. A word completes each time `frame_period` leaves the word code 1.
- R8: Both flags are sticky. A one-cycle pulse on `timeout_clr` or `wclk_err_clr` clears its flag, and an event in the same cycle as the clear leaves the flag set.
- R9: The first frame-clock edge after reset, or after a `wclk_err_clr` pulse, is not checked by the interval rule (R6) or the channel rule (R7). In single-phase mode the first rising edge serves as the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Raw bit clock, asynchronous |
| wclk_in | input | 1 | Raw frame (word) clock, asynchronous |
| dual_phase | input | 1 | 1 = dual-phase rules, 0 = single-phase multichannel rules |
| num_chan | input | CHAN_W | Channel words per frame in single-phase mode |
| frame_period | input | 2 | Sequencer period: 0 data delay, 1 word, 2 idle |
| timeout_clr | input | 1 | Write-1-to-clear strobe for the timeout flag |
| wclk_err_clr | input | 1 | Write-1-to-clear strobe for the framing-error flag; also re-arms the checks |
| timeout_flag | output | 1 | Sticky: frame clock stopped |
| wclk_err_flag | output | 1 | Sticky: framing error, word alignment lost |

## Verification
Each piece of internal state has its own visible symptom at the ports. A wrong bit-clock gap count shows as an error flag that rises, or fails to rise, on the third frame-clock edge of a short or exact-boundary gap. A wrong word count shows on the rising edge that closes a frame. A lost arm bit shows on the very first edge after reset or after a clear. The timeout counter is only visible after a full window of about 65.5 thousand cycles, so the bench watches both sides of that boundary and then checks that a cleared flag stays low while the count is saturated.

// File: rtl/wsup_pkg.sv
package wsup_pkg;

  typedef enum logic [1:0] {
    PER_DELAY = 2'd0,
    PER_WORD  = 2'd1,
    PER_IDLE  = 2'd2,
    PER_SPARE = 2'd3
  } period_e;

  localparam int LANE_WCLK = 0;
  localparam int LANE_BCLK = 1;
  localparam int NUM_LANES = 2;

  localparam int FLAG_TMO  = 0;
  localparam int FLAG_WERR = 1;
  localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/wsup_sync_edge.sv
module wsup_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-1:0], d};
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];

endmodule

// File: rtl/wsup_timeout.sv
module wsup_timeout #(
  parameter int LIMIT = 65535,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          hit,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] MAXV = CW'(LIMIT);
  localparam logic [CW-1:0] PREV = CW'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (count != MAXV) begin
      count <= count + 1'b1;
    end
  end

  // one pulse per window: only on the step into saturation
  assign hit = !restart && (count == PREV);

endmodule

// File: rtl/wsup_frame_check.sv
module wsup_frame_check
  import wsup_pkg::*;
#(
  parameter int CHAN_W  = 4,
  parameter int MIN_GAP = 4,
  localparam int GW     = $clog2(MIN_GAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_phase,
  input  logic [CHAN_W-1:0] num_chan,
  input  period_e           period,
  input  logic              wclk_rise,
  input  logic              wclk_fall,
  input  logic              bclk_rise,
  input  logic              rearm,
  output logic              err_set
);

  localparam logic [GW-1:0]     GAP_MAX  = GW'(MIN_GAP);
  localparam logic [CHAN_W-1:0] WORD_MAX = '1;

  period_e           period_q;
  logic [CHAN_W-1:0] words;
  logic [GW-1:0]     gap;
  logic              armed;
  logic              wclk_any;
  logic              word_done;
  logic              delay_hit;
  logic              gap_hit;
  logic              chan_hit;

  assign wclk_any  = wclk_rise | wclk_fall;
  assign word_done = (period_q == PER_WORD) && (period != PER_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= PER_IDLE;
    end else begin
      period_q <= period;
    end
  end

  // bit-clock rising edges since the last frame-clock edge, saturating
  always_ff @(posedge clk) begin
    if (!rst_n || rearm) begin
      gap <= '0;
    end else if (wclk_any) begin
      gap <= '0;
    end else if (bclk_rise && gap != GAP_MAX) begin
      gap <= gap + 1'b1;
    end
  end

  // completed channel words since the last rising frame-clock edge
  always_ff @(posedge clk) begin
    if (!rst_n || rearm) begin
      words <= '0;
    end else if (wclk_rise) begin
      words <= '0;
    end else if (word_done && words != WORD_MAX) begin
      words <= words + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rearm) begin
      armed <= 1'b0;
    end else if (dual_phase ? wclk_any : wclk_rise) begin
      armed <= 1'b1;
    end
  end

  assign delay_hit = wclk_any && (period == PER_DELAY);
  assign gap_hit   = armed && dual_phase && wclk_any && (gap < GAP_MAX);
  assign chan_hit  = armed && !dual_phase && wclk_rise && (words < num_chan);
  assign err_set   = delay_hit | gap_hit | chan_hit;

endmodule

// File: rtl/wsup_sticky.sv
module wsup_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else begin
      flag <= set | (flag & ~clr);
    end
  end

endmodule

// File: rtl/wclk_supervisor.sv
module wclk_supervisor
  import wsup_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 65535,
  parameter int CHAN_W         = 4,
  parameter int MIN_GAP        = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_in,
  input  logic              wclk_in,
  input  logic              dual_phase,
  input  logic [CHAN_W-1:0] num_chan,
  input  logic [1:0]        frame_period,
  input  logic              timeout_clr,
  input  logic              wclk_err_clr,
  output logic              timeout_flag,
  output logic              wclk_err_flag
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

  logic [NUM_LANES-1:0] raw;
  logic [NUM_LANES-1:0] lvl;
  logic [NUM_LANES-1:0] lvl_prev;
  logic                 wclk_rise;
  logic                 wclk_fall;
  logic                 bclk_rise;
  logic                 to_hit;
  logic [CW-1:0]        to_count;
  logic                 err_set;
  logic [NUM_FLAGS-1:0] f_set;
  logic [NUM_FLAGS-1:0] f_clr;
  logic [NUM_FLAGS-1:0] f_q;

  assign raw[LANE_WCLK] = wclk_in;
  assign raw[LANE_BCLK] = bclk_in;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    wsup_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (raw[g]),
      .q      (lvl[g]),
      .q_prev (lvl_prev[g])
    );
  end

  assign wclk_rise = lvl[LANE_WCLK] & ~lvl_prev[LANE_WCLK];
  assign wclk_fall = ~lvl[LANE_WCLK] & lvl_prev[LANE_WCLK];
  assign bclk_rise = lvl[LANE_BCLK] & ~lvl_prev[LANE_BCLK];

  wsup_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wclk_rise),
    .hit     (to_hit),
    .count   (to_count)
  );

  wsup_frame_check #(.CHAN_W(CHAN_W), .MIN_GAP(MIN_GAP)) u_chk_rules (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_phase (dual_phase),
    .num_chan   (num_chan),
    .period     (period_e'(frame_period)),
    .wclk_rise  (wclk_rise),
    .wclk_fall  (wclk_fall),
    .bclk_rise  (bclk_rise),
    .rearm      (wclk_err_clr),
    .err_set    (err_set)
  );

  assign f_set[FLAG_TMO]  = to_hit;
  assign f_clr[FLAG_TMO]  = timeout_clr;
  assign f_set[FLAG_WERR] = err_set;
  assign f_clr[FLAG_WERR] = wclk_err_clr;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    wsup_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (f_set[f]),
      .clr   (f_clr[f]),
      .flag  (f_q[f])
    );
  end

  assign timeout_flag  = f_q[FLAG_TMO];
  assign wclk_err_flag = f_q[FLAG_WERR];

endmodule

// File: rtl/wclk_supervisor_chk.sv
module wclk_supervisor_chk #(
  parameter int LIMIT = 65535,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wclk_rise,
  input logic          wclk_fall,
  input logic [1:0]    frame_period,
  input logic          to_hit,
  input logic [CW-1:0] to_count,
  input logic          timeout_clr,
  input logic          err_set,
  input logic          wclk_err_clr,
  input logic          timeout_flag,
  input logic          wclk_err_flag
);

  a_r1_flags_low_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!timeout_flag && !wclk_err_flag));

  a_r2_timeout_raises: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> timeout_flag);

  a_r3_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (to_count == CW'(LIMIT) && !wclk_rise) |=> (to_count == CW'(LIMIT)));

  a_r3_rise_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wclk_rise |=> (to_count == '0));

  a_r4_delay_edge_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((wclk_rise || wclk_fall) && frame_period == 2'd0) |=> wclk_err_flag);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_err_flag && !wclk_err_clr) |=> wclk_err_flag);

  a_r8_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !timeout_clr) |=> timeout_flag);

  a_r8_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_err_clr && !err_set) |=> !wclk_err_flag);

  a_r8_err_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!wclk_err_flag && !err_set) |=> !wclk_err_flag);

endmodule

bind wclk_supervisor wclk_supervisor_chk #(.LIMIT(TIMEOUT_CYCLES)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .wclk_rise     (wclk_rise),
  .wclk_fall     (wclk_fall),
  .frame_period  (frame_period),
  .to_hit        (to_hit),
  .to_count      (to_count),
  .timeout_clr   (timeout_clr),
  .err_set       (err_set),
  .wclk_err_clr  (wclk_err_clr),
  .timeout_flag  (timeout_flag),
  .wclk_err_flag (wclk_err_flag)
);

// File: tb/tb_wclk_supervisor.sv
module tb_wclk_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int CHAN_W     = 4;
  localparam int WATCHDOG   = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bclk_in = 1'b0;
  logic              wclk_in = 1'b0;
  logic              dual_phase = 1'b1;
  logic [CHAN_W-1:0] num_chan = 4'd2;
  logic [1:0]        frame_period = 2'd1;
  logic              timeout_clr = 1'b0;
  logic              wclk_err_clr = 1'b0;
  logic              timeout_flag;
  logic              wclk_err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wclk_supervisor dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk_in       (bclk_in),
    .wclk_in       (wclk_in),
    .dual_phase    (dual_phase),
    .num_chan      (num_chan),
    .frame_period  (frame_period),
    .timeout_clr   (timeout_clr),
    .wclk_err_clr  (wclk_err_clr),
    .timeout_flag  (timeout_flag),
    .wclk_err_flag (wclk_err_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bclk_in = 1'b0;
    wclk_in = 1'b0;
    timeout_clr = 1'b0;
    wclk_err_clr = 1'b0;
    frame_period = 2'd1;
    tick(4);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic wtoggle();
    wclk_in = ~wclk_in;
    tick(4);
  endtask

  task automatic bpulses(input int n);
    for (int i = 0; i < n; i++) begin
      bclk_in = 1'b1;
      tick(2);
      bclk_in = 1'b0;
      tick(2);
    end
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) begin
      frame_period = 2'd1;
      tick(2);
      frame_period = 2'd2;
      tick(2);
    end
  endtask

  task automatic clr_err();
    wclk_err_clr = 1'b1;
    tick(1);
    wclk_err_clr = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(3);
    check("R1 timeout flag in reset", timeout_flag, 1'b0);
    check("R1 error flag in reset", wclk_err_flag, 1'b0);
    rst_n = 1'b1;
    tick(1);
    check("R1 timeout flag after release", timeout_flag, 1'b0);
    check("R1 error flag after release", wclk_err_flag, 1'b0);
  endtask

  task automatic t_timeout();
    do_reset();
    dual_phase = 1'b1;
    tick(65520);
    check("R2 no timeout before window", timeout_flag, 1'b0);
    tick(30);
    check("R2 timeout after window", timeout_flag, 1'b1);
    tick(100);
    check("R8 timeout flag sticky", timeout_flag, 1'b1);
    timeout_clr = 1'b1;
    tick(1);
    timeout_clr = 1'b0;
    tick(50);
    check("R3 no refire while saturated", timeout_flag, 1'b0);
    wtoggle();
    check("R5 first edge in word period no error", wclk_err_flag, 1'b0);
    tick(65500);
    check("R3 rise restarted count", timeout_flag, 1'b0);
    tick(50);
    check("R3 timeout after new window", timeout_flag, 1'b1);
  endtask

  task automatic t_dual();
    do_reset();
    dual_phase = 1'b1;
    frame_period = 2'd1;
    wtoggle();
    check("R9 first edge after reset unchecked", wclk_err_flag, 1'b0);
    bpulses(4);
    wtoggle();
    check("R6 gap of 4 accepted", wclk_err_flag, 1'b0);
    frame_period = 2'd2;
    bpulses(5);
    wtoggle();
    check("R5 edge in idle period ignored", wclk_err_flag, 1'b0);
    bpulses(3);
    wtoggle();
    check("R6 gap of 3 flagged", wclk_err_flag, 1'b1);
    tick(20);
    check("R8 error flag sticky", wclk_err_flag, 1'b1);
    clr_err();
    check("R8 error flag cleared", wclk_err_flag, 1'b0);
    wtoggle();
    check("R9 first edge after clear unchecked", wclk_err_flag, 1'b0);
    bpulses(2);
    wtoggle();
    check("R6 gap of 2 flagged", wclk_err_flag, 1'b1);
  endtask

  task automatic t_delay();
    do_reset();
    dual_phase = 1'b1;
    frame_period = 2'd1;
    wtoggle();
    bpulses(6);
    frame_period = 2'd0;
    wclk_in = ~wclk_in;
    tick(3);
    check("R4 delay-period edge flagged within 3 cycles", wclk_err_flag, 1'b1);
    tick(1);
    clr_err();
    check("R8 cleared before priority test", wclk_err_flag, 1'b0);
    wtoggle();
    bpulses(6);
    wclk_in = ~wclk_in;
    tick(2);
    wclk_err_clr = 1'b1;
    tick(1);
    wclk_err_clr = 1'b0;
    check("R8 set wins over clear", wclk_err_flag, 1'b1);
    tick(2);
    clr_err();
    dual_phase = 1'b0;
    tick(2);
    wtoggle();
    check("R4 delay-period edge single mode", wclk_err_flag, 1'b1);
    frame_period = 2'd1;
  endtask

  task automatic t_single();
    do_reset();
    dual_phase = 1'b0;
    num_chan = 4'd3;
    frame_period = 2'd2;
    wtoggle();
    check("R9 first rise single mode unchecked", wclk_err_flag, 1'b0);
    words(1);
    wtoggle();
    words(2);
    wtoggle();
    check("R7 full frame of 3 words accepted", wclk_err_flag, 1'b0);
    words(2);
    wtoggle();
    check("R7 fall mid-frame not checked", wclk_err_flag, 1'b0);
    wtoggle();
    check("R7 rise after 2 of 3 words flagged", wclk_err_flag, 1'b1);
    clr_err();
    wtoggle();
    wtoggle();
    check("R9 rise after clear unchecked", wclk_err_flag, 1'b0);
    words(3);
    wtoggle();
    wtoggle();
    check("R7 3 words accepted after rearm", wclk_err_flag, 1'b0);
    num_chan = 4'd1;
    words(1);
    wtoggle();
    wtoggle();
    check("R7 one channel frame accepted", wclk_err_flag, 1'b0);
    wtoggle();
    wtoggle();
    check("R7 rise with no word flagged", wclk_err_flag, 1'b1);
  endtask

  initial begin
    tick(2);
    t_reset();
    t_timeout();
    t_dual();
    t_delay();
    t_single();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule